// File: doc/BRIEF.md
# Calibrated Seconds Prescaler with Periodic Rate Correction

This block turns a stream of oscillator enable pulses (nominally 32,768 per second) into a one-clock pulse at the end of every second and another at the end of every minute. It corrects the rate digitally. Instead of trimming the crystal, it makes selected seconds a little shorter or longer. A 64-minute schedule decides which seconds are touched. A signed 5-bit calibration value sets how many minutes of that schedule carry an adjusted second and in which direction.

A free-running test divider produces a square wave at 1/64 of the tick rate (512 Hz at the nominal rate). This wave never sees the correction, so a production tester can measure the raw oscillator error on it. A halt input freezes every counter. The calendar counters, the oscillator itself, the pin driver and any register access are left to the surrounding logic.

Top module: `calpre_top`

## Requirements
- R1: With no correction active, a second lasts exactly 2^(LO_W+HI_W) enabled ticks (32768 by default).
- R2: When `cal_fast` is 1, a corrected second ends 2^LO_W ticks early (256 by default, giving 32512).
- R3: When `cal_fast` is 0, a corrected second ends 2^(LO_W-1) ticks late (128 by default, giving 32896).
- R4: Minutes are numbered 0 to 63 in a repeating cycle that starts at 0 after reset. With magnitude N on `cal_mag`, only the first second (index 0) of each minute numbered below 2N is corrected. N = 0 corrects nothing, and N = 31 corrects minutes 0 to 61.
- R5: `min_tick` is high for one clock, in the same cycle as the `sec_tick` that ends the last second of a minute (second index SEC_PER_MIN-1). It is never high without `sec_tick`.
- R6: `cal_fast` and `cal_mag` are sampled while `rst` is high and again at each minute boundary. A change in the middle of a minute has no effect until the next minute starts.
- R7: While `halt` is 1, no tick is counted, neither `sec_tick` nor `min_tick` rises, and `ft_wave` holds its level. After `halt` clears, counting resumes from the held state.
- R8: `ft_wave` toggles every 2^(LO_W-3) enabled ticks, whatever the calibration setting.
- R9: Synchronous active-high reset clears every counter. `sec_tick`, `min_tick` and `ft_wave` read 0 afterwards.
- R10: Only clock cycles with `osc_en` high advance the divider. Second lengths are counted in enabled ticks, whatever the gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle enable per oscillator tick |
| halt | input | 1 | Freezes all counting when 1 |
| cal_fast | input | 1 | Correction sign: 1 shortens, 0 lengthens |
| cal_mag | input | 5 | Correction magnitude N (0 to 31) |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| ft_wave | output | 1 | Uncorrected test square wave |

## Verification
The bench runs a reduced divider (16 by 8 ticks, four seconds per minute) so that a whole 64-minute cycle fits in the run. Each second is compared against a length computed from the bench's own minute and cycle model.

The stimulus covers the following cases:
- Magnitude 1 with a positive sign separates the corrected minutes 0–1 from the untouched minute 2.
- Magnitude 6 with a negative sign and gapped enables checks the lengthened second and the counting in ticks rather than clocks.
- Magnitude 31 over a full cycle and into the next one checks the 62-minute edge and the wrap back to minute 0. Magnitude 0 shows that nothing is adjusted.
- A mid-minute change of the magnitude, and a halt window inside a second, separate deferred sampling from immediate sampling, and a true freeze from a lost count.

// File: rtl/calpre_pkg.sv
package calpre_pkg;

    localparam int MAG_W = 5;
    localparam int CYC_W = 6;   // 64-minute correction cycle

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_FAST = 2'd1,
        ADJ_SLOW = 2'd2
    } adj_e;

    typedef struct packed {
        logic             fast;
        logic [MAG_W-1:0] mag;
    } cal_t;

    // Final count value of a second, given the adjustment kind.
    function automatic int unsigned sec_last(adj_e a, int lo_w, int hi_w);
        int unsigned base;
        base = 32'd1 << (lo_w + hi_w);
        case (a)
            ADJ_FAST: return base - (32'd1 << lo_w) - 1;
            ADJ_SLOW: return base + (32'd1 << (lo_w - 1)) - 1;
            default:  return base - 1;
        endcase
    endfunction

    // True when the cycle minute lies inside the first 2N minutes.
    function automatic logic in_window(logic [CYC_W-1:0] minute,
                                       logic [MAG_W-1:0] mag);
        return minute < {mag, 1'b0};
    endfunction

endpackage

// File: rtl/calpre_sched.sv
module calpre_sched
    import calpre_pkg::*;
#(
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  cal_t cal_in,
    output adj_e adj,
    output logic min_end
);
    localparam int SW = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);

    logic [SW-1:0]    sec_idx;
    logic [CYC_W-1:0] cyc_min;
    cal_t             cal_q;

    assign min_end = adv && (sec_idx == SEC_LAST);

    always_comb begin
        adj = ADJ_NONE;
        if (sec_idx == '0 && in_window(cyc_min, cal_q.mag))
            adj = cal_q.fast ? ADJ_FAST : ADJ_SLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_idx <= '0;
            cyc_min <= '0;
            cal_q   <= cal_in;
        end else if (adv) begin
            if (min_end) begin
                sec_idx <= '0;
                cyc_min <= cyc_min + 1'b1;
                cal_q   <= cal_in;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end

    // R6: calibration is only picked up at a minute boundary
    p_cal_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(cal_q));

    // R4: cycle minute moves only at a minute boundary, by one
    p_cycle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !min_end |=> $stable(cyc_min));
    p_cycle_step_r4: assert property (@(posedge clk) disable iff (rst)
        min_end |=> cyc_min == CYC_W'($past(cyc_min) + 1'b1));

endmodule

// File: rtl/calpre_secdiv.sv
module calpre_secdiv
    import calpre_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  adj_e adj,
    output logic sec_end
);
    localparam int CW = LO_W + HI_W + 1;
    localparam logic [CW-1:0] MAX_LAST = CW'(sec_last(ADJ_SLOW, LO_W, HI_W));

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last    = CW'(sec_last(adj, LO_W, HI_W));
    assign sec_end = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= sec_end ? '0 : cnt + 1'b1;
    end

    // R3: no second runs past the longest (lengthened) value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAX_LAST);

endmodule

// File: rtl/calpre_ftdiv.sv
module calpre_ftdiv #(
    parameter int FT_BIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic ft
);
    logic [FT_BIT:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign ft = cnt[FT_BIT];

endmodule

// File: rtl/calpre_top.sv
module calpre_top
    import calpre_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int HI_W        = 7,
    parameter int SEC_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             halt,
    input  logic             cal_fast,
    input  logic [MAG_W-1:0] cal_mag,
    output logic             sec_tick,
    output logic             min_tick,
    output logic             ft_wave
);
    localparam int FT_BIT = LO_W - 3;

    logic step;
    logic sec_end;
    logic min_end;
    adj_e adj;
    cal_t cal_in;

    assign step   = osc_en && !halt;
    assign cal_in = '{fast: cal_fast, mag: cal_mag};

    calpre_sched #(.SEC_PER_MIN(SEC_PER_MIN)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .adv     (sec_end),
        .cal_in  (cal_in),
        .adj     (adj),
        .min_end (min_end)
    );

    calpre_secdiv #(.LO_W(LO_W), .HI_W(HI_W)) u_secdiv (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .adj     (adj),
        .sec_end (sec_end)
    );

    calpre_ftdiv #(.FT_BIT(FT_BIT)) u_ftdiv (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .ft   (ft_wave)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_tick <= 1'b0;
            min_tick <= 1'b0;
        end else begin
            sec_tick <= sec_end;
            min_tick <= min_end;
        end
    end

    // R5: minute pulse coincides with a second pulse
    p_min_in_sec_r5: assert property (@(posedge clk) disable iff (rst)
        min_tick |-> sec_tick);

    // R7: halted cycles produce no pulses and freeze the test wave
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        halt |=> !sec_tick && !min_tick);
    p_ft_hold_r7: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(ft_wave));

endmodule

// File: tb/test_calpre_top.sv
module test_calpre_top;
    localparam int LO      = 4;
    localparam int HI      = 3;
    localparam int SPM     = 4;
    localparam int NOM     = 1 << (LO + HI);
    localparam int FAST    = NOM - (1 << LO);
    localparam int SLOW    = NOM + (1 << (LO - 1));
    localparam int FT_HALF = 1 << (LO - 3);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       halt = 1'b0;
    logic       cal_fast = 1'b0;
    logic [4:0] cal_mag = '0;
    logic       sec_tick, min_tick, ft_wave;

    calpre_top #(.LO_W(LO), .HI_W(HI), .SEC_PER_MIN(SPM)) i_calpre_top (
        .clk(clk), .rst(rst), .osc_en(osc_en), .halt(halt),
        .cal_fast(cal_fast), .cal_mag(cal_mag),
        .sec_tick(sec_tick), .min_tick(min_tick), .ft_wave(ft_wave)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int tick_cnt = 0, ft_cnt = 0, bsec = 0, bmin = 0, secs_seen = 0, cyc = 0;
    logic bfast = 1'b0;
    logic [4:0] bmag = '0;
    logic ft_prev = 1'b0;
    string phase = "R9";

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s/%s actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    // R4: correction lands on second 0 of minutes below 2N
    function automatic int exp_len();
        if (bsec == 0 && bmin < 2 * int'(bmag)) return bfast ? FAST : SLOW;
        return NOM;
    endfunction

    task automatic observe();
        int e;
        if (sec_tick) begin
            e = exp_len();
            check(tick_cnt == e, (e == NOM) ? "R1" : (e == FAST) ? "R2" : "R3",
                  tick_cnt, e);
            check(min_tick == (bsec == SPM - 1), "R5", int'(min_tick),
                  int'(bsec == SPM - 1));
            tick_cnt = 0;
            secs_seen++;
            if (bsec == SPM - 1) begin
                bsec  = 0;
                bmin  = (bmin + 1) % 64;
                bfast = cal_fast;
                bmag  = cal_mag;
            end else begin
                bsec++;
            end
        end else if (min_tick) begin
            check(1'b0, "R5", 1, 0);
        end
        if (ft_wave != ft_prev) begin
            check(ft_cnt == FT_HALF, "R8", ft_cnt, FT_HALF);
            ft_cnt  = 0;
            ft_prev = ft_wave;
        end
    endtask

    task automatic step_cycle(bit en, bit h);
        @(negedge clk);
        observe();
        osc_en = en;
        halt   = h;
        if (en && !h) begin
            tick_cnt++;
            ft_cnt++;
        end
        cyc++;
    endtask

    task automatic do_reset();
        rst = 1'b1; osc_en = 1'b0; halt = 1'b0;
        repeat (3) @(negedge clk);
        phase = "R9";
        check(!sec_tick && !min_tick && !ft_wave, "R9",
              int'({sec_tick, min_tick, ft_wave}), 0);
        bsec = 0; bmin = 0; bfast = cal_fast; bmag = cal_mag;
        tick_cnt = 0; ft_cnt = 0; ft_prev = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_secs(int n, int gap);
        int target;
        target = secs_seen + n;
        while (secs_seen < target)
            step_cycle(gap == 0 || (cyc % (gap + 1)) == 0, 1'b0);
    endtask

    initial begin
        int bad;
        logic ft_hold;
        // N=1 positive: minutes 0-1 shortened, minutes 2-3 nominal
        cal_fast = 1'b1; cal_mag = 5'd1;
        do_reset(); phase = "R4";
        run_secs(16, 0);

        // N=6 negative with gapped enables: R10
        cal_fast = 1'b0; cal_mag = 5'd6;
        do_reset(); phase = "R10";
        run_secs(56, 1);

        // R6: change mid-minute only applies from the next minute
        cal_fast = 1'b1; cal_mag = 5'd0;
        do_reset(); phase = "R6";
        repeat (50) step_cycle(1'b1, 1'b0);
        cal_mag = 5'd1;
        run_secs(12, 0);

        // R7: halt inside a second freezes everything
        phase = "R7";
        repeat (60) step_cycle(1'b1, 1'b0);
        bad = 0;
        ft_hold = 1'b0;
        for (int i = 0; i < 200; i++) begin
            step_cycle(1'b1, 1'b1);
            if (i == 0) ft_hold = ft_wave;
            else if (sec_tick || min_tick || ft_wave != ft_hold) bad++;
        end
        check(bad == 0, "R7", bad, 0);
        run_secs(8, 0);

        // N=31 positive: full 64-minute cycle plus wrap into the next
        cal_fast = 1'b1; cal_mag = 5'd31;
        do_reset(); phase = "R4";
        run_secs(264, 0);

        // N=0 negative: nothing corrected
        cal_fast = 1'b0; cal_mag = 5'd0;
        do_reset(); phase = "R4";
        run_secs(12, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", secs_seen, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule